// File: doc/BRIEF.md
# Serial ADC Frame Reader

This controller sits on the host side of a three-wire link to a delta-sigma converter. The three wires are an active-low chip select, a serial clock and a serial data line. When a single-cycle `start_i` request arrives, the reader lowers chip select. It waits a short settle interval and then looks at the data line. While the converter is still converting, that line reads 1. In that case the reader raises chip select again, waits a programmable back-off interval and polls once more. Once the line reads 0, the reader drives a divided serial clock and shifts the frame in, sampling on each rising edge.

A frame starts with 4 status bits, most significant first. The first of these is the readiness bit itself. Then come 20 result bits, most significant first. In the long mode the reader issues 8 extra clocks. The converter always drives 1 on those padding bits, so the reader treats them as an integrity check.

After the last falling clock edge the reader raises chip select, which lets the converter begin its next conversion. On the next cycle it presents the status, the data and a padding-error flag, together with a single-cycle valid strobe. The frame mode is taken from `long_mode_i` at the moment the request is accepted.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `cs_n_o` is 1 and `sck_o`, `busy_o` and `valid_o` are 0.
- R2: `sck_o` is 0 in every cycle in which `cs_n_o` is 1.
- R3: After a request, `cs_n_o` goes low for DIV cycles and `sdo_i` is sampled before any clock edge. If the sample is 1, `cs_n_o` rises again with no `sck_o` pulse.
- R4: After a busy poll, `cs_n_o` stays high for exactly RETRY_WAIT cycles and then falls again for the next poll.
- R5: A read issues exactly 24 `sck_o` rising edges in short mode (`long_mode_i`=0) and exactly 32 in long mode (`long_mode_i`=1).
- R6: During a read, each high phase of `sck_o` lasts DIV cycles, and so does each low phase between two pulses.
- R7: The bit sampled at the n-th rising edge of `sck_o` lands as follows. Edges 1 to 4 fill `status_o[3:0]`, most significant bit first. Edges 5 to 24 fill `data_o[19:0]`, most significant bit first.
- R8: `valid_o` is high for exactly one cycle, in the first cycle after `cs_n_o` rises at the end of a completed read.
- R9: `pad_err_o` goes high with `valid_o` only in long mode, and only if any of the bits sampled at edges 25 to 32 was 0. In short mode it is 0.
- R10: `busy_o` equals the inverse of `cs_n_o` in every cycle.
- R11: A `start_i` pulse that arrives while a read is in progress is ignored. No further chip-select activity follows the read.
- R12: The frame length is fixed by `long_mode_i` when the request is accepted. A later change on that input does not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle read request |
| long_mode_i | input | 1 | 1 selects the 32-clock frame, 0 the 24-clock frame |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | High while chip select is low |
| valid_o | output | 1 | Single-cycle result strobe |
| status_o | output | 4 | Status bits of the last frame |
| data_o | output | 20 | Result bits of the last frame |
| pad_err_o | output | 1 | Padding bit seen as 0 in long mode |

## Verification
The assertions assume that `start_i` is a clean synchronous pulse. They also assume that the converter changes `sdo_i` only after a falling edge of `sck_o` or a falling edge of chip select, never right before a rising edge. The converter model in the bench updates the data line half a system clock after it sees the reader's edge, so every sample the reader takes is settled. Every ready frame the model returns carries a 0 in its first status bit. Busy polls hold the line at 1 for the whole chip-select window.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    RD_IDLE    = 3'd0,
    RD_SETTLE  = 3'd1,
    RD_BACKOFF = 3'd2,
    RD_SHIFT   = 3'd3,
    RD_DONE    = 3'd4
  } rd_state_e;
endpackage

// File: rtl/adc_rd_tick.sv
// Divider: emits one tick every DIV cycles while run is high.
module adc_rd_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_rd_shifter.sv
// Serial-in shift register with a count of captured bits.
module adc_rd_shifter #(
  parameter int LEN = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     cap,
  input  logic                     din,
  output logic [LEN-1:0]           bits,
  output logic [$clog2(LEN+1)-1:0] count
);
  localparam int NW = $clog2(LEN + 1);

  logic [LEN-1:0] sh_q, sh_d;
  logic [NW-1:0]  n_q, n_d;

  always_comb begin
    sh_d = sh_q;
    n_d  = n_q;
    if (clr) begin
      sh_d = '0;
      n_d  = '0;
    end else if (cap) begin
      sh_d = {sh_q[LEN-2:0], din};
      n_d  = n_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      n_q  <= '0;
    end else begin
      sh_q <= sh_d;
      n_q  <= n_d;
    end
  end

  assign bits  = sh_q;
  assign count = n_q;
endmodule

// File: rtl/adc_rd_ctrl.sv
// Sequencer: poll, back-off, clock generation and completion.
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int RETRY_WAIT = 10,
  parameter int NW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  input  logic          sdo,
  input  logic [NW-1:0] bit_cnt,
  input  logic [NW-1:0] frame_len,
  output rd_state_e     state,
  output logic          sck,
  output logic          run,
  output logic          cap,
  output logic          clr,
  output logic          fin,
  output logic          accept
);
  localparam int WW = $clog2(RETRY_WAIT + 1);

  rd_state_e st_q, st_d;
  logic      sck_q, sck_d;
  logic [WW-1:0] wait_q, wait_d;

  always_comb begin
    st_d   = st_q;
    sck_d  = 1'b0;
    wait_d = '0;
    cap    = 1'b0;
    clr    = 1'b0;
    fin    = 1'b0;
    accept = 1'b0;
    unique case (st_q)
      RD_IDLE: begin
        if (start) begin
          st_d   = RD_SETTLE;
          accept = 1'b1;
        end
      end
      RD_SETTLE: begin
        if (tick) begin
          clr  = 1'b1;
          st_d = sdo ? RD_BACKOFF : RD_SHIFT;
        end
      end
      RD_BACKOFF: begin
        wait_d = wait_q + 1'b1;
        if (wait_q == WW'(RETRY_WAIT - 1)) begin
          st_d   = RD_SETTLE;
          wait_d = '0;
        end
      end
      RD_SHIFT: begin
        sck_d = sck_q;
        if (tick) begin
          sck_d = ~sck_q;
          cap   = ~sck_q;
          if (sck_q && (bit_cnt == frame_len)) begin
            st_d = RD_DONE;
            fin  = 1'b1;
          end
        end
      end
      RD_DONE: st_d = RD_IDLE;
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      sck_q  <= 1'b0;
      wait_q <= '0;
    end else begin
      st_q   <= st_d;
      sck_q  <= sck_d;
      wait_q <= wait_d;
    end
  end

  assign state = st_q;
  assign sck   = sck_q;
  assign run   = (st_q == RD_SETTLE) || (st_q == RD_SHIFT);
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int DIV        = 2,
  parameter int RETRY_WAIT = 10,
  parameter int STATUS_W   = 4,
  parameter int DATA_W     = 20,
  parameter int PAD_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              long_mode_i,
  input  logic              sdo_i,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [STATUS_W-1:0] status_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pad_err_o
);
  localparam int SHORT_LEN = STATUS_W + DATA_W;
  localparam int LONG_LEN  = SHORT_LEN + PAD_W;
  localparam int NW        = $clog2(LONG_LEN + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  rd_state_e         state;
  logic              tick, run, cap, clr, fin, accept, sck;
  logic [LONG_LEN-1:0] bits;
  logic [NW-1:0]     count;
  logic              long_q;
  logic [NW-1:0]     frame_len;

  assign frame_len = long_q ? NW'(LONG_LEN) : NW'(SHORT_LEN);

  adc_rd_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_core_n), .run(run), .tick(tick)
  );

  adc_rd_shifter #(.LEN(LONG_LEN)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .clr(clr), .cap(cap),
    .din(sdo_i), .bits(bits), .count(count)
  );

  adc_rd_ctrl #(.RETRY_WAIT(RETRY_WAIT), .NW(NW)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .start(start_i), .tick(tick),
    .sdo(sdo_i), .bit_cnt(count), .frame_len(frame_len),
    .state(state), .sck(sck), .run(run), .cap(cap), .clr(clr),
    .fin(fin), .accept(accept)
  );

  // frame fields picked out according to the latched mode
  logic [STATUS_W-1:0] stat_d;
  logic [DATA_W-1:0]   data_d;
  logic                perr_d;

  always_comb begin
    if (long_q) begin
      stat_d = bits[LONG_LEN-1 -: STATUS_W];
      data_d = bits[LONG_LEN-STATUS_W-1 -: DATA_W];
      perr_d = ~&bits[PAD_W-1:0];
    end else begin
      stat_d = bits[SHORT_LEN-1 -: STATUS_W];
      data_d = bits[DATA_W-1:0];
      perr_d = 1'b0;
    end
  end

  logic [STATUS_W-1:0] stat_q;
  logic [DATA_W-1:0]   data_q;
  logic                perr_q, valid_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      long_q  <= 1'b0;
      stat_q  <= '0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fin;
      if (accept) long_q <= long_mode_i;
      if (fin) begin
        stat_q <= stat_d;
        data_q <= data_d;
        perr_q <= perr_d;
      end
    end
  end

  assign cs_n_o    = !((state == RD_SETTLE) || (state == RD_SHIFT));
  assign busy_o    = (state == RD_SETTLE) || (state == RD_SHIFT);
  assign sck_o     = sck;
  assign valid_o   = valid_q;
  assign status_o  = stat_q;
  assign data_o    = data_q;
  assign pad_err_o = perr_q;
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int DIV      = 2,
  parameter int LONG_LEN = 32
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic busy,
  input logic valid,
  input logic pad_err
);
  logic [15:0] hi_cnt;
  logic [7:0]  rise_cnt;
  logic        sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      rise_cnt <= '0;
      sck_q    <= 1'b0;
    end else begin
      sck_q  <= sck;
      hi_cnt <= sck ? hi_cnt + 1'b1 : 16'd0;
      if (cs_n)              rise_cnt <= '0;
      else if (sck && !sck_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_busy_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);
  p_high_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hi_cnt == 16'(DIV)));
  p_pulse_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= 8'(LONG_LEN));
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_valid_after_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cs_n && $past(!cs_n)));
  p_pad_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(pad_err));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(.DIV(DIV), .LONG_LEN(LONG_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n_o), .sck(sck_o),
  .busy(busy_o), .valid(valid_o), .pad_err(pad_err_o)
);

// File: tb/adc_frame_reader_test.sv
`timescale 1ns/1ps
module adc_frame_reader_test;
  localparam int DIV   = 2;
  localparam int RETRY = 10;

  logic clk, rst_n, start_i, long_mode_i, sdo_i;
  logic cs_n_o, sck_o, busy_o, valid_o, pad_err_o;
  logic [3:0]  status_o;
  logic [19:0] data_o;

  adc_frame_reader #(.DIV(DIV), .RETRY_WAIT(RETRY)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_mode_i(long_mode_i),
    .sdo_i(sdo_i), .cs_n_o(cs_n_o), .sck_o(sck_o), .busy_o(busy_o),
    .valid_o(valid_o), .status_o(status_o), .data_o(data_o), .pad_err_o(pad_err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural converter and reference state
  logic [31:0] word;
  int  polls_left = 0;
  bit  conv_busy = 0;
  int  idx = 0;
  int  rises = 0;
  int  exp_len = 24;
  bit  exp_long = 0;
  bit  prev_cs = 1, prev_sck = 0, prev_valid = 0;
  int  gap = 0;
  bit  gap_on = 0;
  int  lvl_len = 0;
  int  phase_bad = 0;
  int  frames = 0;
  int  cs_falls = 0;
  int  cycles = 0;
  bit  model_on = 0;

  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      check(!(cs_n_o && sck_o), "R2", sck_o, 0);
      check(busy_o == !cs_n_o, "R10", busy_o, !cs_n_o);
      if (prev_cs && !cs_n_o) begin
        cs_falls++;
        if (gap_on) begin
          check(gap == RETRY, "R4", gap, RETRY);
          gap_on = 0;
        end
        conv_busy = (polls_left > 0);
        if (polls_left > 0) polls_left--;
        idx = 0; rises = 0; lvl_len = 0; phase_bad = 0;
      end else if (!cs_n_o) begin
        if (sck_o != prev_sck) begin
          if (prev_sck && lvl_len != DIV) phase_bad++;
          if (!prev_sck && rises > 0 && lvl_len != DIV) phase_bad++;
          lvl_len = 1;
        end else lvl_len++;
        if (prev_sck && !sck_o) idx++;
        if (!prev_sck && sck_o) rises++;
      end
      if (cs_n_o && gap_on) gap++;
      if (!prev_cs && cs_n_o) begin
        if (conv_busy) begin
          check(rises == 0, "R3", rises, 0);
          gap_on = 1; gap = 1;
        end else begin
          check(rises == exp_len, "R5", rises, exp_len);
          check(phase_bad == 0, "R6", phase_bad, 0);
        end
      end
      if (valid_o) begin
        frames++;
        check(!prev_cs, "R8", prev_cs, 0);
        check(status_o == word[31:28], "R7", status_o, word[31:28]);
        check(data_o == word[27:8], "R7", data_o, word[27:8]);
        check(pad_err_o == (exp_long && word[7:0] != 8'hFF), "R9",
              pad_err_o, (exp_long && word[7:0] != 8'hFF));
      end
      if (prev_valid) check(!valid_o, "R8", valid_o, 0);
      prev_cs = cs_n_o; prev_sck = sck_o; prev_valid = valid_o;
    end
    if (cs_n_o || conv_busy) sdo_i = 1'b1;
    else sdo_i = (idx < 32) ? word[31-idx] : 1'b1;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic read_frame(input bit lm, input logic [31:0] w, input int polls,
                            input bit flip, input bit extra);
    int f0;
    f0 = frames;
    word = w; polls_left = polls; exp_long = lm; exp_len = lm ? 32 : 24;
    long_mode_i = lm;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (flip || extra) begin
      while (conv_busy || cs_n_o) @(negedge clk);
      repeat (20) @(negedge clk);
      if (flip) long_mode_i = ~lm;   // R12: must not change the length
      if (extra) begin                // R11: request during a read
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
      end
    end
    for (int t = 0; t < 5000 && frames == f0; t++) @(negedge clk);
    check(frames == f0 + 1, "R8", frames - f0, 1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; long_mode_i = 1'b0; sdo_i = 1'b1; word = '0;
    repeat (3) @(negedge clk);
    check(cs_n_o && !sck_o && !busy_o && !valid_o, "R1",
          {cs_n_o, sck_o, busy_o, valid_o}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1;

    read_frame(1'b0, 32'h3A5C_E1FF, 0, 0, 0);  // R5 R7 short
    read_frame(1'b1, 32'h1234_56FF, 0, 0, 0);  // R9 clean padding
    read_frame(1'b1, 32'h6FED_CBF7, 0, 0, 0);  // R9 one zero in padding
    read_frame(1'b0, 32'h7000_0100, 0, 0, 0);  // R9 short ignores padding
    read_frame(1'b1, 32'h0ABC_DEFF, 2, 0, 0);  // R3 R4 busy polls
    read_frame(1'b1, 32'h5555_5500, 0, 1, 0);  // R12 mode change mid read
    begin
      int falls0;
      read_frame(1'b0, 32'h2468_ACFF, 0, 0, 1); // R11
      falls0 = cs_falls;
      repeat (200) @(negedge clk);
      check(cs_falls == falls0 && cs_n_o, "R11", cs_falls - falls0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule